// File: doc/BRIEF.md
# Smart Card Character Transmitter with Retry

This block sends bytes to a smart card over the single shared, open-drain I/O line. Each byte goes out as one character: a low start bit, eight data bits with the least significant bit first, and an even parity bit. Each bit lasts one elementary time unit (etu), and an `etu_tick` pulse marks the end of each etu. The block pulls the line only for low bits and releases it at all other times.

Between its own characters it keeps a programmable character guard time. After the card finishes a character, it keeps a programmable block guard time. When handshaking is enabled, it checks the line one etu after each parity bit. A low level there means the card rejected the character. The block then waits four etu and sends the character again. Once the retry limit is used up, it stops, raises a sticky error and refuses new bytes until a flush.

Bytes arrive on a valid/ready stream. `s_ready` is high only when no byte is held and no error is pending. A byte is accepted on a clock edge where `s_valid` and `s_ready` are both high. That byte is kept, and resent if needed, until it is delivered or flushed. A producer may hold `s_valid` and `s_data` for any length of time while `s_ready` is low.

Top module: `sc_tx`

## Requirements
- R1: A character is a start bit (line pulled), the eight data bits LSB first, and then a parity bit. The parity bit makes the data and parity bits together even. Each bit holds for one etu, starting at an `etu_tick`. `line_drive`=1 means the line is pulled low, and it is 1 only for low bits.
- R2: With handshaking off, the number of etu ticks from the tick that ends a parity bit to the tick that begins the next start bit equals `max(chguard, 1)`. This holds when the next byte is already waiting.
- R3: With handshaking on, `line_in` is sampled on the first tick after the parity bit ends. A high level accepts the character, and the next one starts `max(chguard, 2)` ticks after the parity bit ended.
- R4: A low `line_in` at the handshake sample rejects the character. The same character then restarts exactly 4 ticks after the sample, which is 5 ticks after its parity bit ended.
- R5: A character is sent at most `retry_limit`+1 times. A rejection of the last attempt sets `tx_err`. `tx_err` stays set until a flush. While it is set the line stays released.
- R6: A one-cycle `flush` clears `tx_err`, discards the held byte and any character in progress, and raises `s_ready`.
- R7: A pulse on `card_char_end` (the card's character has ended) delays the next start bit. The start bit cannot begin until `blkguard` full ticks have passed after the pulse, so it begins on the (`blkguard`+1)-th tick after it at the earliest. A pulse in the same cycle as a tick that would otherwise start a character defers that start.
- R8: `s_ready` is low while a byte is held or `tx_err` is set, and no byte is taken then.
- R9: After reset, `line_drive`=0, `tx_err`=0 and `s_ready`=1.
- R10: With handshaking off, `line_in` has no effect: a low level after a character causes no resend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| etu_tick | input | 1 | One-cycle pulse at each etu boundary |
| s_valid | input | 1 | Byte stream valid |
| s_ready | output | 1 | Byte stream ready |
| s_data | input | DW | Byte to send |
| hs_en | input | 1 | Enable per-character handshake check |
| chguard | input | GW | Character guard time in etu |
| blkguard | input | GW | Block guard time in etu after a card character |
| retry_limit | input | RW | Maximum number of resends per character |
| card_char_end | input | 1 | Pulse: the card's last character has ended |
| line_in | input | 1 | Sensed level of the I/O line |
| flush | input | 1 | Discard the held byte and clear the error |
| line_drive | output | 1 | 1 = pull the I/O line low |
| tx_err | output | 1 | Sticky transmit-abort flag |

## Verification
The block guard event and the character-guard decision can fall in the same cycle. This happens when the card's end-of-character pulse lands on the very tick at which a waiting byte would otherwise begin its start bit. The bench provokes this by first starting a block guard wait with one pulse. It then places a second pulse exactly on the tick where the start was due. The bench judges the result by checking that the line stays released on that tick and on the next two, and that the start bit appears on the third tick after the second pulse.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_HSCHK,
    ST_BACKOFF,
    ST_ABORT
  } tx_state_t;
endpackage

// File: rtl/sc_tx_frame.sv
module sc_tx_frame #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic          adv,
  input  logic [DW-1:0] data_i,
  output logic          line_low_o,
  output logic          last_o
);
  localparam int FRAME = DW + 2;
  localparam int IW    = $clog2(FRAME);

  logic [FRAME-1:0] shreg;
  logic [IW-1:0]    idx;
  logic             active;

  assign last_o     = active && (idx == IW'(FRAME - 1));
  assign line_low_o = active && !shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '1;
      idx    <= '0;
      active <= 1'b0;
    end else if (clear) begin
      shreg  <= '1;
      idx    <= '0;
      active <= 1'b0;
    end else if (load) begin
      shreg  <= {^data_i, data_i, 1'b0};
      idx    <= '0;
      active <= 1'b1;
    end else if (adv && active) begin
      if (last_o) begin
        shreg  <= '1;
        idx    <= '0;
        active <= 1'b0;
      end else begin
        shreg <= {1'b1, shreg[FRAME-1:1]};
        idx   <= idx + 1'b1;
      end
    end
  end

  // R1: bit index never leaves the frame
  p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IW'(FRAME - 1));

  // R1: a freshly loaded frame carries even parity over data and parity bit
  p_even_parity_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> (^shreg[FRAME-1:1] == 1'b0) && !shreg[0]);
endmodule

// File: rtl/sc_tx_guard.sv
module sc_tx_guard #(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          char_end,
  input  logic          card_end,
  input  logic [GW-1:0] chguard,
  input  logic [GW-1:0] blkguard,
  output logic          ok_o
);
  localparam logic [GW-1:0] SAT = '1;

  logic [GW-1:0] own_gap;
  logic [GW-1:0] card_gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_gap <= SAT;
    end else if (char_end) begin
      own_gap <= GW'(1);
    end else if (tick && own_gap != SAT) begin
      own_gap <= own_gap + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      card_gap <= SAT;
    end else if (card_end) begin
      card_gap <= '0;
    end else if (tick && card_gap != SAT) begin
      card_gap <= card_gap + 1'b1;
    end
  end

  assign ok_o = !card_end && (own_gap >= chguard) && (card_gap >= blkguard);

  // R7: a card event always restarts the block guard count
  p_card_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    card_end |=> card_gap == '0);

  // R2: the own-character gap restarts at one after each parity bit
  p_own_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    char_end |=> own_gap == GW'(1));
endmodule

// File: rtl/sc_tx_ctrl.sv
module sc_tx_ctrl
  import sc_tx_pkg::*;
#(
  parameter int DW      = 8,
  parameter int RW      = 3,
  parameter int BACKOFF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          flush,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic          hs_en,
  input  logic [RW-1:0] retry_limit,
  input  logic          line_in,
  input  logic          gap_ok,
  input  logic          last_bit,
  output logic          load,
  output logic          adv,
  output logic          char_end,
  output logic [DW-1:0] hold_data,
  output logic          tx_err,
  output tx_state_t     state_o
);
  localparam int BW = $clog2(BACKOFF + 1);

  tx_state_t     st, nxt;
  logic          hold_v;
  logic [RW-1:0] tries;
  logic [BW-1:0] bo;
  logic          err;
  logic          pop, nack_retry, abort;

  assign s_ready = !hold_v && !err;
  assign tx_err  = err;
  assign state_o = st;

  always_comb begin
    nxt        = st;
    load       = 1'b0;
    adv        = 1'b0;
    char_end   = 1'b0;
    pop        = 1'b0;
    nack_retry = 1'b0;
    abort      = 1'b0;
    case (st)
      ST_IDLE: begin
        if (tick && hold_v && gap_ok) begin
          load = 1'b1;
          nxt  = ST_SEND;
        end
      end
      ST_SEND: begin
        if (tick) begin
          adv = 1'b1;
          if (last_bit) begin
            char_end = 1'b1;
            if (hs_en) begin
              nxt = ST_HSCHK;
            end else begin
              nxt = ST_IDLE;
              pop = 1'b1;
            end
          end
        end
      end
      ST_HSCHK: begin
        if (tick) begin
          if (line_in) begin
            nxt = ST_IDLE;
            pop = 1'b1;
          end else if (tries == retry_limit) begin
            nxt   = ST_ABORT;
            abort = 1'b1;
          end else begin
            nxt        = ST_BACKOFF;
            nack_retry = 1'b1;
          end
        end
      end
      ST_BACKOFF: begin
        if (tick && bo == BW'(BACKOFF - 1)) begin
          load = 1'b1;
          nxt  = ST_SEND;
        end
      end
      ST_ABORT: nxt = ST_ABORT;
      default:  nxt = ST_IDLE;
    endcase
    if (flush) begin
      nxt        = ST_IDLE;
      load       = 1'b0;
      adv        = 1'b0;
      char_end   = 1'b0;
      pop        = 1'b0;
      nack_retry = 1'b0;
      abort      = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      hold_v    <= 1'b0;
      hold_data <= '0;
      tries     <= '0;
      bo        <= '0;
      err       <= 1'b0;
    end else begin
      st <= nxt;
      if (flush || pop) begin
        hold_v <= 1'b0;
      end else if (s_valid && s_ready) begin
        hold_v    <= 1'b1;
        hold_data <= s_data;
      end
      if (flush || (st == ST_IDLE && load)) begin
        tries <= '0;
      end else if (nack_retry) begin
        tries <= tries + 1'b1;
      end
      if (nack_retry) begin
        bo <= '0;
      end else if (st == ST_BACKOFF && tick) begin
        bo <= bo + 1'b1;
      end
      if (flush) begin
        err <= 1'b0;
      end else if (abort) begin
        err <= 1'b1;
      end
    end
  end

  // R5: error flag holds until flushed
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !flush) |=> err);

  // R5: resend count stays inside the programmed limit while backing off
  p_tries_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BACKOFF) |-> (tries <= retry_limit));

  // R4: back-off never overruns its length
  p_backoff_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BACKOFF) |-> (bo < BW'(BACKOFF)));

  // R6: flush leaves an idle, error-free, empty transmitter
  p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!err && !hold_v && st == ST_IDLE));

  // R8: an accepted byte is held
  p_accept_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !flush) |=> hold_v);
endmodule

// File: rtl/sc_tx.sv
module sc_tx
  import sc_tx_pkg::*;
#(
  parameter int DW      = 8,
  parameter int GW      = 8,
  parameter int RW      = 3,
  parameter int BACKOFF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          etu_tick,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic          hs_en,
  input  logic [GW-1:0] chguard,
  input  logic [GW-1:0] blkguard,
  input  logic [RW-1:0] retry_limit,
  input  logic          card_char_end,
  input  logic          line_in,
  input  logic          flush,
  output logic          line_drive,
  output logic          tx_err
);
  logic          gap_ok, last_bit, load, adv, char_end;
  logic [DW-1:0] hold_data;
  tx_state_t     st;

  sc_tx_ctrl #(.DW(DW), .RW(RW), .BACKOFF(BACKOFF)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (etu_tick),
    .flush      (flush),
    .s_valid    (s_valid),
    .s_ready    (s_ready),
    .s_data     (s_data),
    .hs_en      (hs_en),
    .retry_limit(retry_limit),
    .line_in    (line_in),
    .gap_ok     (gap_ok),
    .last_bit   (last_bit),
    .load       (load),
    .adv        (adv),
    .char_end   (char_end),
    .hold_data  (hold_data),
    .tx_err     (tx_err),
    .state_o    (st)
  );

  sc_tx_frame #(.DW(DW)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (flush),
    .load      (load),
    .adv       (adv),
    .data_i    (hold_data),
    .line_low_o(line_drive),
    .last_o    (last_bit)
  );

  sc_tx_guard #(.GW(GW)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (etu_tick),
    .char_end(char_end),
    .card_end(card_char_end),
    .chguard (chguard),
    .blkguard(blkguard),
    .ok_o    (gap_ok)
  );

  // R2: a new character leaves idle only with both guard times satisfied
  p_start_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_IDLE && st == ST_SEND) |-> $past(gap_ok));

  // R5: line stays released after an abort
  p_abort_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ABORT) |-> !line_drive);

  // R7: a card event seen in idle defers any start on that edge
  p_card_defers_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (card_char_end && st == ST_IDLE) |=> st != ST_SEND);
endmodule

// File: tb/sc_tx_tb.sv
module sc_tx_tb;
  logic       clk = 1'b0, rst_n = 1'b0, etu_tick = 1'b0;
  logic       s_valid = 1'b0, hs_en = 1'b0, card_char_end = 1'b0;
  logic       line_in = 1'b1, flush = 1'b0;
  logic [7:0] s_data = '0, chguard = '0, blkguard = '0;
  logic [2:0] retry_limit = '0;
  logic       s_ready, line_drive, tx_err;
  int errs = 0, checks = 0, ticks_after = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sc_tx u_dut (
    .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .hs_en(hs_en), .chguard(chguard),
    .blkguard(blkguard), .retry_limit(retry_limit), .card_char_end(card_char_end),
    .line_in(line_in), .flush(flush), .line_drive(line_drive), .tx_err(tx_err)
  );

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      etu_tick = 1'b1;
      @(negedge clk);
      etu_tick = 1'b0;
    end
  end

  function automatic logic [9:0] fr(input logic [7:0] d);
    return {^d, d, 1'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (etu_tick !== 1'b1);
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    while (s_ready !== 1'b1) @(negedge clk);
    s_data  = d;
    s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic capture(input bit nack, output logic [9:0] bits, output int gap);
    int n = ticks_after;
    do begin wait_tick(); n++; end while (!line_drive && n < 600);
    gap = n;
    bits[0] = ~line_drive;
    for (int i = 1; i < 10; i++) begin wait_tick(); bits[i] = ~line_drive; end
    wait_tick();
    ticks_after = 0;
    if (hs_en) begin
      line_in = ~nack;
      wait_tick();
      line_in = 1'b1;
      ticks_after = 1;
    end
  endtask

  task automatic quiet_ticks(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin wait_tick(); if (line_drive) hits++; end
  endtask

  task automatic t_reset();
    chk(line_drive == 1'b0, "R9", "line_drive after reset", line_drive, 0);
    chk(tx_err == 1'b0, "R9", "tx_err after reset", tx_err, 0);
    chk(s_ready == 1'b1, "R9", "s_ready after reset", s_ready, 1);
  endtask

  task automatic t_plain();
    logic [9:0] b; int g;
    hs_en = 0; chguard = 8'd3; line_in = 1'b0;  // low line must be ignored (R10)
    fork
      begin push(8'hA5); push(8'h07); end
      begin
        capture(0, b, g);
        chk(b == fr(8'hA5), "R1", "frame A5", b, fr(8'hA5));
        capture(0, b, g);
        chk(b == fr(8'h07), "R10", "next byte sent, no resend", b, fr(8'h07));
        chk(g == 3, "R2", "guard gap chguard=3", g, 3);
      end
    join
    chguard = 8'd0;
    fork
      begin push(8'h11); push(8'h22); end
      begin
        capture(0, b, g);
        capture(0, b, g);
        chk(b == fr(8'h22), "R1", "frame 22", b, fr(8'h22));
        chk(g == 1, "R2", "guard gap chguard=0", g, 1);
      end
    join
    line_in = 1'b1;
  endtask

  task automatic t_hs_ack();
    logic [9:0] b; int g;
    hs_en = 1; chguard = 8'd0;
    fork
      begin push(8'h5A); push(8'hC3); end
      begin
        capture(0, b, g);
        chk(b == fr(8'h5A), "R3", "frame 5A", b, fr(8'h5A));
        capture(0, b, g);
        chk(b == fr(8'hC3), "R3", "accepted, next byte", b, fr(8'hC3));
        chk(g == 2, "R3", "handshake gap", g, 2);
      end
    join
  endtask

  task automatic t_retry();
    logic [9:0] b; int g;
    hs_en = 1; retry_limit = 3'd2; chguard = 8'd4;
    fork
      begin push(8'h96); push(8'h3F); end
      begin
        capture(1, b, g);
        chk(b == fr(8'h96), "R4", "first attempt", b, fr(8'h96));
        capture(0, b, g);
        chk(b == fr(8'h96), "R4", "resend same byte", b, fr(8'h96));
        chk(g == 5, "R4", "back-off gap", g, 5);
        capture(0, b, g);
        chk(b == fr(8'h3F), "R3", "after retry, next byte", b, fr(8'h3F));
        chk(g == 4, "R3", "guard gap chguard=4", g, 4);
      end
    join
    chk(tx_err == 1'b0, "R5", "no error after recovered retry", tx_err, 0);
  endtask

  task automatic t_abort(input logic [2:0] lim);
    logic [9:0] b; int g; int hits;
    hs_en = 1; retry_limit = lim; chguard = 8'd2;
    fork
      push(8'h6E);
      begin
        for (int i = 0; i <= int'(lim); i++) begin
          capture(1, b, g);
          chk(b == fr(8'h6E), "R5", "attempt data", b, fr(8'h6E));
          if (i > 0) chk(g == 5, "R4", "resend gap", g, 5);
        end
      end
    join
    chk(tx_err == 1'b1, "R5", "error after last rejection", tx_err, 1);
    chk(s_ready == 1'b0, "R8", "ready low on error", s_ready, 0);
    @(negedge clk); s_data = 8'h77; s_valid = 1'b1;
    repeat (5) @(negedge clk);
    s_valid = 1'b0;
    quiet_ticks(20, hits);
    chk(hits == 0, "R5", "line quiet after abort", hits, 0);
    chk(tx_err == 1'b1, "R5", "error sticky", tx_err, 1);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    chk(tx_err == 1'b0, "R6", "flush clears error", tx_err, 0);
    chk(s_ready == 1'b1, "R6", "flush frees stream", s_ready, 1);
    quiet_ticks(10, hits);
    chk(hits == 0, "R6", "held byte dropped by flush", hits, 0);
    ticks_after = 0;
    fork
      push(8'hE1);
      capture(0, b, g);
    join
    chk(b == fr(8'hE1), "R6", "sending resumes after flush", b, fr(8'hE1));
  endtask

  task automatic t_block();
    int n = 0; int dummy;
    hs_en = 0; chguard = 8'd0; blkguard = 8'd3;
    wait_tick();
    card_char_end = 1'b1; s_data = 8'h81; s_valid = 1'b1;
    @(negedge clk);
    card_char_end = 1'b0; s_valid = 1'b0;
    do begin wait_tick(); n++; end while (!line_drive && n < 100);
    chk(n == 4, "R7", "block guard start tick", n, 4);
    quiet_ticks(11, dummy);
  endtask

  task automatic t_same_cycle();
    int dummy;
    hs_en = 0; chguard = 8'd0; blkguard = 8'd2;
    wait_tick();
    repeat (3) @(negedge clk);
    card_char_end = 1'b1; s_data = 8'h42; s_valid = 1'b1;
    @(negedge clk);
    card_char_end = 1'b0; s_valid = 1'b0;
    wait_tick();
    wait_tick();
    chk(line_drive == 1'b0, "R7", "still waiting before due tick", line_drive, 0);
    repeat (3) @(negedge clk);
    card_char_end = 1'b1;  // lands on the tick where the start was due
    @(negedge clk);
    card_char_end = 1'b0;
    chk(line_drive == 1'b0, "R7", "same-cycle card event defers start", line_drive, 0);
    wait_tick();
    chk(line_drive == 1'b0, "R7", "deferred one", line_drive, 0);
    wait_tick();
    chk(line_drive == 1'b0, "R7", "deferred two", line_drive, 0);
    wait_tick();
    chk(line_drive == 1'b1, "R7", "start third tick after event", line_drive, 1);
    quiet_ticks(11, dummy);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_hs_ack();
    t_retry();
    t_abort(3'd1);
    t_abort(3'd0);
    t_block();
    t_same_cycle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule